// File: doc/BRIEF.md
# SDRAM Refresh Scheduler with Self-Refresh Control

This block keeps the rows of an SDRAM device refreshed on time. It sits beside the command arbiter of the memory controller. A programmable interval timer marks each point at which the device needs a refresh. The block then raises a request toward the arbiter. When the arbiter grants the request, the block takes over the command bus. It issues a precharge-all to close every bank and waits out the row-precharge time. It then issues the auto-refresh command and holds a busy flag high for the refresh recovery window, so the arbiter issues nothing else in that time. The refresh command carries no address, because the device steps its own internal row counter.

If the arbiter cannot grant in time, intervals that expire while a refresh is still outstanding are counted, up to a limit. A single later grant then drains all of them back to back. The block also controls the clock-enable pin. A sleep input closes the banks and issues a refresh with clock enable low, which puts the device into self-refresh. The device stays there, ignoring every other input, until a wake input raises clock enable again. A recovery window follows before normal commands resume.

Top module: `sdram_refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, refresh_req and busy are low, cke is high, a10 is low and cmd shows NOP. Command codes on cmd are {cs_n, ras_n, cas_n, we_n}: NOP = 4'b0111, PRECHARGE = 4'b0010, REFRESH = 4'b0001.
- R2: After reset is released, refresh_req is still low after INTERVAL_CYC-1 rising edges and is high after the INTERVAL_CYC-th rising edge.
- R3: Once high, refresh_req stays high until a grant or a sleep request is taken. A refresh_gnt pulse while refresh_req is low has no effect: cmd stays NOP and busy stays low.
- R4: On the clock edge that samples refresh_gnt together with refresh_req, the block starts the refresh sequence. The cycle after that edge shows PRECHARGE with a10 high. TRP_CYC cycles of NOP follow, then one REFRESH cycle, then TRFC_CYC cycles of NOP. busy then returns low.
- R5: busy is high from the PRECHARGE cycle to the end of the last recovery window, and refresh_req is low during that time. While busy is low, cmd is NOP.
- R6: The REFRESH command is always issued with a10 low. a10 is high only during a PRECHARGE.
- R7: Interval expiries are accumulated up to PEND_MAX outstanding refreshes, and further expiries are dropped. One grant drains all of them. Each extra REFRESH follows the previous recovery window directly, with no further PRECHARGE.
- R8: A sleep_req sampled while idle takes priority over a grant in the same cycle. It produces PRECHARGE (a10 high), TRP_CYC cycles of NOP, then REFRESH with cke low. After that, cke stays low, cmd stays NOP and busy stays high.
- R9: While in self-refresh, refresh_gnt and sleep_req are ignored and refresh_req stays low. Refreshes that were outstanding at entry are discarded.
- R10: A wake_req sampled in self-refresh raises cke in the next cycle, together with TRFC_CYC cycles of NOP with busy high. busy then returns low, and the interval timer starts again from zero, so refresh_req rises after INTERVAL_CYC more rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_gnt | input | 1 | Arbiter grants the bus for refresh |
| sleep_req | input | 1 | Request to enter self-refresh |
| wake_req | input | 1 | Request to leave self-refresh |
| refresh_req | output | 1 | Refresh outstanding, asking the arbiter for the bus |
| busy | output | 1 | Block owns the command bus; arbiter must stall |
| cmd | output | 4 | Command code {cs_n, ras_n, cas_n, we_n} |
| a10 | output | 1 | Address bit 10; high selects all banks on precharge |
| cke | output | 1 | SDRAM clock enable |

## Verification
The refresh sequence is tried with one outstanding refresh, with two, and with more expiries than the limit allows. Comparing the number of REFRESH cycles in each run shows correct accumulation, saturation and back-to-back draining, without a precharge between refreshes. A grant given with no request outstanding, and a request left ungranted for a while, separate a correct handshake from one that starts or drops on its own. The sleep path is driven with a request already outstanding and a grant given in the same cycle. Grants and sleep pulses are then held through a long stay in self-refresh. This exposes priority errors, inputs leaking through while clock enable is low, stale pending refreshes and a timer that fails to restart after wake-up.

// File: rtl/rfsh_pkg.sv
`timescale 1ns/1ps
package rfsh_pkg;

  typedef enum logic [3:0] {
    CMD_NOP     = 4'b0111,
    CMD_PRECHG  = 4'b0010,
    CMD_REFRESH = 4'b0001
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_TRP, ST_REF, ST_BUSY, ST_SR_IN, ST_SR, ST_SR_OUT
  } seq_state_e;

  // saturating update of the outstanding refresh count
  function automatic int pend_next(int cur, bit inc, bit dec, int lim);
    int v;
    v = cur;
    if (dec && v > 0) v = v - 1;
    if (inc && v < lim) v = v + 1;
    return v;
  endfunction

  // value loaded into a down-counter so the wait lasts 'cycles' cycles
  function automatic int wait_load(int cycles);
    return (cycles > 0) ? cycles - 1 : 0;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
`timescale 1ns/1ps
module rfsh_interval_timer #(
  parameter int INTERVAL_CYC = 781
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic tick
);
  localparam int CW = $clog2(INTERVAL_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(INTERVAL_CYC - 1);

  logic [CW-1:0] cnt;

  assign tick = !hold && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || hold) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // R2: the count never runs past the interval end
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R2: a tick is always followed by a fresh count
  a_r2_wrap_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == '0));

endmodule

// File: rtl/rfsh_pend_counter.sv
`timescale 1ns/1ps
module rfsh_pend_counter #(
  parameter int PEND_MAX = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic consume,
  input  logic flush,
  output logic has_work
);
  import rfsh_pkg::*;
  localparam int PW = $clog2(PEND_MAX + 1);

  logic [PW-1:0] pending;

  assign has_work = (pending != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) pending <= '0;
    else pending <= PW'(pend_next(int'(pending), tick, consume, PEND_MAX));
  end

  // R7: outstanding count stays bounded
  a_r7_pend_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pending) <= PEND_MAX);

  // R7: a refresh is only consumed when one is outstanding
  a_r7_consume_has_work: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> has_work);

endmodule

// File: rtl/rfsh_sequencer.sv
`timescale 1ns/1ps
module rfsh_sequencer #(
  parameter int TRP_CYC  = 3,
  parameter int TRFC_CYC = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       has_work,
  input  logic       gnt,
  input  logic       sleep,
  input  logic       wake,
  output logic       req,
  output logic       busy,
  output logic [3:0] cmd,
  output logic       a10,
  output logic       cke,
  output logic       consume,
  output logic       flush,
  output logic       timer_hold
);
  import rfsh_pkg::*;
  localparam int MAXW = (TRP_CYC > TRFC_CYC) ? TRP_CYC : TRFC_CYC;
  localparam int WW = $clog2(MAXW + 1);
  localparam logic [WW-1:0] TRP_LD  = WW'(wait_load(TRP_CYC));
  localparam logic [WW-1:0] TRFC_LD = WW'(wait_load(TRFC_CYC));

  seq_state_e    state;
  logic [WW-1:0] wcnt;
  logic          to_sleep;
  logic          wait_done;

  assign wait_done = (wcnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      wcnt     <= '0;
      to_sleep <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sleep) begin
            state    <= ST_PRE;
            to_sleep <= 1'b1;
          end else if (gnt && has_work) begin
            state    <= ST_PRE;
            to_sleep <= 1'b0;
          end
        end
        ST_PRE: begin
          state <= ST_TRP;
          wcnt  <= TRP_LD;
        end
        ST_TRP: begin
          if (wait_done) state <= to_sleep ? ST_SR_IN : ST_REF;
          else wcnt <= wcnt - 1'b1;
        end
        ST_REF: begin
          state <= ST_BUSY;
          wcnt  <= TRFC_LD;
        end
        ST_BUSY: begin
          if (wait_done) state <= has_work ? ST_REF : ST_IDLE;
          else wcnt <= wcnt - 1'b1;
        end
        ST_SR_IN: state <= ST_SR;
        ST_SR: begin
          if (wake) begin
            state <= ST_SR_OUT;
            wcnt  <= TRFC_LD;
          end
        end
        ST_SR_OUT: begin
          if (wait_done) state <= ST_IDLE;
          else wcnt <= wcnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // named internal events
  assign consume    = (state == ST_REF);
  assign flush      = (state == ST_SR_IN);
  assign timer_hold = (state == ST_SR_IN) || (state == ST_SR) || (state == ST_SR_OUT);

  always_comb begin
    case (state)
      ST_PRE:             cmd = CMD_PRECHG;
      ST_REF, ST_SR_IN:   cmd = CMD_REFRESH;
      default:            cmd = CMD_NOP;
    endcase
  end

  assign a10  = (state == ST_PRE);
  assign cke  = !((state == ST_SR_IN) || (state == ST_SR));
  assign busy = (state != ST_IDLE);
  assign req  = has_work && (state == ST_IDLE);

  // R4: a precharge is always followed by a NOP cycle
  a_r4_pre_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PRECHG) |=> (cmd == CMD_NOP));

  // R4: a refresh is always followed by a NOP cycle
  a_r4_ref_then_nop: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REFRESH) |=> (cmd == CMD_NOP));

  // R5: outside the owned window the bus shows NOP
  a_r5_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (cmd == CMD_NOP));

  // R5: no request while the bus is owned
  a_r5_no_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req);

  // R6: refresh carries no address bit
  a_r6_refresh_a10_low: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REFRESH) |-> !a10);

  // R8: clock enable drops only together with a refresh command
  a_r8_cke_fall_with_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> (cmd == CMD_REFRESH));

  // R10: clock enable rises only after a wake request
  a_r10_cke_rise_on_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(wake));

endmodule

// File: rtl/sdram_refresh_sched.sv
`timescale 1ns/1ps
module sdram_refresh_sched #(
  parameter int INTERVAL_CYC = 781,
  parameter int TRP_CYC      = 3,
  parameter int TRFC_CYC     = 9,
  parameter int PEND_MAX     = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       refresh_gnt,
  input  logic       sleep_req,
  input  logic       wake_req,
  output logic       refresh_req,
  output logic       busy,
  output logic [3:0] cmd,
  output logic       a10,
  output logic       cke
);
  logic tick;
  logic has_work;
  logic consume;
  logic flush;
  logic timer_hold;

  rfsh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) timer_i (
    .clk(clk), .rst_n(rst_n), .hold(timer_hold), .tick(tick)
  );

  rfsh_pend_counter #(.PEND_MAX(PEND_MAX)) pend_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .consume(consume),
    .flush(flush), .has_work(has_work)
  );

  rfsh_sequencer #(.TRP_CYC(TRP_CYC), .TRFC_CYC(TRFC_CYC)) seq_i (
    .clk(clk), .rst_n(rst_n), .has_work(has_work), .gnt(refresh_gnt),
    .sleep(sleep_req), .wake(wake_req), .req(refresh_req), .busy(busy),
    .cmd(cmd), .a10(a10), .cke(cke), .consume(consume), .flush(flush),
    .timer_hold(timer_hold)
  );

  // R3: an outstanding request is held until it is taken
  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !refresh_gnt && !sleep_req) |=> refresh_req);

  // R9: no request while clock enable is low
  a_r9_no_req_in_sr: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> !refresh_req);

endmodule

// File: tb/sdram_refresh_sched_tb.sv
`timescale 1ns/1ps
module sdram_refresh_sched_tb_top;
  localparam int INTERVAL = 40;
  localparam int TRP      = 2;
  localparam int TRFC     = 9;
  localparam int PMAX     = 3;
  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] PRE = 4'b0010;
  localparam logic [3:0] REF = 4'b0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refresh_gnt = 1'b0;
  logic sleep_req = 1'b0;
  logic wake_req = 1'b0;
  logic refresh_req, busy, a10, cke;
  logic [3:0] cmd;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sdram_refresh_sched #(
    .INTERVAL_CYC(INTERVAL), .TRP_CYC(TRP), .TRFC_CYC(TRFC), .PEND_MAX(PMAX)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .refresh_gnt(refresh_gnt), .sleep_req(sleep_req),
    .wake_req(wake_req), .refresh_req(refresh_req), .busy(busy), .cmd(cmd),
    .a10(a10), .cke(cke)
  );

  always @(posedge clk) cycles <= cycles + 1;

  initial begin
    wait (cycles > 20000);
    errors = errors + 1;
    $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // compares {cmd, a10, busy, cke, refresh_req}
  task automatic chk(string tag, logic [3:0] ec, logic ea, logic eb, logic ek, logic er);
    logic [7:0] act, exp;
    act = {cmd, a10, busy, cke, refresh_req};
    exp = {ec, ea, eb, ek, er};
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual cmd=%b a10=%b busy=%b cke=%b req=%b expected cmd=%b a10=%b busy=%b cke=%b req=%b",
               tag, act[7:4], act[3], act[2], act[1], act[0],
               exp[7:4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic do_reset();
    refresh_gnt = 1'b0; sleep_req = 1'b0; wake_req = 1'b0;
    rst_n = 1'b0;
    step(); step();
    chk("R1 in reset", NOP, 1'b0, 1'b0, 1'b1, 1'b0);
    rst_n = 1'b1;
  endtask

  task automatic wait_edges(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // grant in this cycle, then follow the whole sequence for n refreshes
  task automatic grant_and_follow(string tag, int n);
    refresh_gnt = 1'b1;
    step();
    refresh_gnt = 1'b0;
    chk({tag, " R4 precharge"}, PRE, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < TRP; i++) begin
      step();
      chk({tag, " R4 trp nop"}, NOP, 1'b0, 1'b1, 1'b1, 1'b0);
    end
    for (int r = 0; r < n; r++) begin
      step();
      chk({tag, " R6 R7 refresh"}, REF, 1'b0, 1'b1, 1'b1, 1'b0);
      for (int j = 0; j < TRFC; j++) begin
        step();
        chk({tag, " R5 busy window"}, NOP, 1'b0, 1'b1, 1'b1, 1'b0);
      end
    end
    step();
    chk({tag, " R5 released"}, NOP, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_reset_and_interval();
    do_reset();
    chk("R1 after reset", NOP, 1'b0, 1'b0, 1'b1, 1'b0);
    wait_edges(INTERVAL - 1);
    chk("R2 before interval", NOP, 1'b0, 1'b0, 1'b1, 1'b0);
    step();
    chk("R2 at interval", NOP, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_handshake();
    do_reset();
    wait_edges(5);
    refresh_gnt = 1'b1;
    step();
    refresh_gnt = 1'b0;
    chk("R3 stray grant ignored", NOP, 1'b0, 1'b0, 1'b1, 1'b0);
    wait_edges(INTERVAL - 6);
    chk("R3 req raised", NOP, 1'b0, 1'b0, 1'b1, 1'b1);
    wait_edges(10);
    chk("R3 req held", NOP, 1'b0, 1'b0, 1'b1, 1'b1);
    grant_and_follow("single", 1);
  endtask

  task automatic t_drain(int intervals, int expect_n, string tag);
    do_reset();
    wait_edges(INTERVAL * intervals);
    chk({tag, " R7 req pending"}, NOP, 1'b0, 1'b0, 1'b1, 1'b1);
    grant_and_follow(tag, expect_n);
  endtask

  task automatic t_self_refresh();
    do_reset();
    wait_edges(INTERVAL);
    chk("R8 req before sleep", NOP, 1'b0, 1'b0, 1'b1, 1'b1);
    sleep_req = 1'b1; refresh_gnt = 1'b1;
    step();
    sleep_req = 1'b0; refresh_gnt = 1'b0;
    chk("R8 sleep precharge", PRE, 1'b1, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < TRP; i++) begin
      step();
      chk("R8 sleep trp nop", NOP, 1'b0, 1'b1, 1'b1, 1'b0);
    end
    step();
    chk("R8 refresh with cke low", REF, 1'b0, 1'b1, 1'b0, 1'b0);
    step();
    chk("R8 in self-refresh", NOP, 1'b0, 1'b1, 1'b0, 1'b0);
    refresh_gnt = 1'b1; sleep_req = 1'b1;
    for (int i = 0; i < 2 * INTERVAL; i++) begin
      step();
      chk("R9 inputs ignored", NOP, 1'b0, 1'b1, 1'b0, 1'b0);
    end
    refresh_gnt = 1'b0; sleep_req = 1'b0;
    wake_req = 1'b1;
    step();
    wake_req = 1'b0;
    chk("R10 cke raised", NOP, 1'b0, 1'b1, 1'b1, 1'b0);
    for (int i = 1; i < TRFC; i++) begin
      step();
      chk("R10 exit window", NOP, 1'b0, 1'b1, 1'b1, 1'b0);
    end
    step();
    chk("R10 R9 idle, old request discarded", NOP, 1'b0, 1'b0, 1'b1, 1'b0);
    wait_edges(INTERVAL - 1);
    chk("R10 timer restarted, not yet", NOP, 1'b0, 1'b0, 1'b1, 1'b0);
    step();
    chk("R10 timer restarted, req", NOP, 1'b0, 1'b0, 1'b1, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_reset_and_interval();
    t_handshake();
    t_drain(2, 2, "double");
    t_drain(5, PMAX, "saturated");
    t_self_refresh();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule